// File: doc/BRIEF.md
# Four-Requester Shared Bus Arbiter

This block decides which of four requesters owns a shared parallel bus. Requester index 0 is the internal host-processor request. Indices 1, 2 and 3 are external bus masters 0, 1 and 2. A 2-bit mode input selects the policy. Code 0 is fixed priority, code 1 is rotating round-robin, code 2 is hybrid (host fixed on top, the external masters rotate among themselves) and code 3 is ping-pong between the host and the external group. The grant is a registered one-hot vector. All other pins are plain control and status levels, so the block has no valid/ready interface.

Grants are decided only while the bus is idle. A decision happens when nobody owns the bus, when the owner has dropped its request, or in the first idle cycle after a transaction ends (bus_idle rising). The arbiter takes the grant away in three cases. A retry strikes the owner, which is then kept out for a programmed number of cycles. The owner leaves the bus idle for too long, which raises a dead pulse and keeps that master out until it drops its request. While the lock input is high the grant is frozen on its current owner.

Top module: `bus_arbiter4`

## Requirements
- R1: `gnt` is always zero or one-hot. A decision made while `req` is all zero gives `gnt == 0`. After reset `gnt == 0` and `dead == 0`.
- R2: In mode 0 (fixed), eligible requesters are granted in the order index 0 (host), 1, 2, 3.
- R3: In mode 1 (rotating), the search starts one index above the last granted index, wrapping from 3 to 0. The last granted requester is therefore the lowest priority. After reset the last granted index is 3.
- R4: In mode 2 (hybrid), the host (index 0) wins whenever it is eligible. Otherwise indices 1..3 rotate, starting one above the last granted external index and wrapping from 3 to 1. After reset the last external index is 3.
- R5: In mode 3 (ping-pong), when the host and at least one external master are both eligible, the host wins if the previous grant went to an external master. An external master wins, chosen by the external rotation of R4, if the previous grant went to the host. If only one group requests, that group is served.
- R6: A decision, which updates `gnt` at the next clock edge, occurs only when `bus_idle` is high and one of these holds: no owner, the owner's `req` bit is low, or `bus_idle` was low in the previous cycle. While `bus_idle` is low, `gnt` holds unless a retry strikes.
- R7: `retry` high while a grant exists and `lock` is low clears `gnt` at the next edge. The owner is then not eligible for `retry_lim` further decision cycles: with limit L, the earliest regrant is L+1 edges after the grant was cleared. `retry_lim == 0` applies no mask.
- R8: With `dead_lim = D > 0`, an owner that has been granted for D consecutive idle cycles without `bus_idle` falling loses the grant at the next edge. In the cycle after that edge, `dead` is high for one cycle. `dead_lim == 0` disables the timeout.
- R9: A master that timed out under R8 is not eligible until its `req` bit has been seen low.
- R10: While `lock` is high, `gnt` does not change, and retries and timeouts are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 4 | Requests: bit 0 host, bits 1..3 external masters 0..2 |
| bus_idle | input | 1 | High when no transaction is on the bus |
| retry | input | 1 | Current owner was retried by its target |
| lock | input | 1 | Owner holds a locked sequence |
| mode | input | 2 | Policy: 0 fixed, 1 rotating, 2 hybrid, 3 ping-pong |
| dead_lim | input | TW | Idle cycles allowed before an owner is declared dead (0 = off) |
| retry_lim | input | TW | Cycles a retried master is masked (0 = off) |
| gnt | output | 4 | One-hot grant, same bit order as req |
| dead | output | 1 | One-cycle pulse when an owner timed out |

## Verification
The bench builds the block with its default timer width of 4 bits. It programs limits of 3 for the retry mask and the dead timer, which keeps both windows short enough to check edge by edge: the masked cycles, the first regrant, and the exact edge of the timeout. It also drives both limits to 0 to show that each mechanism switches off. Each policy is reached through a scripted history of earlier grants, so the rotation pointers are in a known state when each order is checked.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NREQ = 4;
  localparam int IW   = $clog2(NREQ);

  typedef enum logic [1:0] {
    ARB_FIXED    = 2'd0,
    ARB_ROTATE   = 2'd1,
    ARB_HYBRID   = 2'd2,
    ARB_PINGPONG = 2'd3
  } arb_mode_e;

  function automatic logic [IW-1:0] oh2idx(logic [NREQ-1:0] v);
    logic [IW-1:0] idx;
    idx = '0;
    for (int i = 0; i < NREQ; i++)
      if (v[i]) idx = IW'(i);
    return idx;
  endfunction

  function automatic logic [NREQ-1:0] first_low(logic [NREQ-1:0] e);
    logic [NREQ-1:0] r;
    r = '0;
    for (int i = NREQ-1; i >= 0; i--)
      if (e[i]) r = NREQ'(1) << i;
    return r;
  endfunction

  function automatic logic [NREQ-1:0] rot_all(logic [NREQ-1:0] e, logic [IW-1:0] last);
    logic [NREQ-1:0] r;
    logic found;
    r = '0;
    found = 1'b0;
    for (int k = 0; k < NREQ; k++) begin
      int j;
      j = (int'(last) + 1 + k) % NREQ;
      if (e[j] && !found) begin
        r = NREQ'(1) << j;
        found = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [NREQ-1:0] rot_ext(logic [NREQ-1:0] e, logic [IW-1:0] last_ext);
    logic [NREQ-1:0] r;
    logic found;
    r = '0;
    found = 1'b0;
    for (int k = 0; k < NREQ-1; k++) begin
      int j;
      j = ((int'(last_ext) + k) % (NREQ-1)) + 1;
      if (e[j] && !found) begin
        r = NREQ'(1) << j;
        found = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
(
  input  logic [1:0]      mode,
  input  logic [NREQ-1:0] elig,
  input  logic [IW-1:0]   last,
  input  logic [IW-1:0]   last_ext,
  output logic [NREQ-1:0] pick
);
  logic            host_e;
  logic            ext_e;
  logic [NREQ-1:0] host_oh;
  logic [NREQ-1:0] ext_pick;

  assign host_e   = elig[0];
  assign ext_e    = |elig[NREQ-1:1];
  assign host_oh  = NREQ'(1);
  assign ext_pick = rot_ext(elig, last_ext);

  always_comb begin
    pick = '0;
    case (arb_mode_e'(mode))
      ARB_FIXED:  pick = first_low(elig);
      ARB_ROTATE: pick = rot_all(elig, last);
      ARB_HYBRID: pick = host_e ? host_oh : ext_pick;
      default: begin
        if (host_e && ext_e)
          pick = (last == '0) ? ext_pick : host_oh;
        else if (host_e)
          pick = host_oh;
        else
          pick = ext_pick;
      end
    endcase
  end
endmodule

// File: rtl/arb_retry_mask.sv
module arb_retry_mask
  import arb_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] load,
  input  logic [TW-1:0]   lim,
  output logic [NREQ-1:0] masked
);
  for (genvar i = 0; i < NREQ; i++) begin : g_cnt
    logic [TW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt <= '0;
      else if (load[i])
        cnt <= lim;
      else if (cnt != '0)
        cnt <= cnt - TW'(1);
    end
    assign masked[i] = (cnt != '0);
  end
endmodule

// File: rtl/bus_arbiter4.sv
module bus_arbiter4
  import arb_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  input  logic            bus_idle,
  input  logic            retry,
  input  logic            lock,
  input  logic [1:0]      mode,
  input  logic [TW-1:0]   dead_lim,
  input  logic [TW-1:0]   retry_lim,
  output logic [NREQ-1:0] gnt,
  output logic            dead
);
  logic [NREQ-1:0] masked;
  logic [NREQ-1:0] dead_vec;
  logic [NREQ-1:0] elig;
  logic [NREQ-1:0] pick;
  logic [IW-1:0]   last;
  logic [IW-1:0]   last_ext;
  logic [IW-1:0]   pick_idx;
  logic [TW-1:0]   dcnt;
  logic [TW:0]     dnext;
  logic            idle_q;
  logic            have_owner;
  logic            owner_req;
  logic            tx_done;
  logic            retry_hit;
  logic            timeout;
  logic            rearb;

  assign have_owner = |gnt;
  assign owner_req  = |(gnt & req);
  assign tx_done    = bus_idle & ~idle_q;
  assign dnext      = {1'b0, dcnt} + {{TW{1'b0}}, 1'b1};
  assign retry_hit  = have_owner & retry & ~lock;
  assign timeout    = have_owner & bus_idle & ~lock & (dead_lim != '0) &
                      (dnext >= {1'b0, dead_lim});
  assign rearb      = ~lock & ~retry_hit & ~timeout & bus_idle &
                      (~have_owner | ~owner_req | tx_done);
  assign elig       = req & ~masked & ~dead_vec;
  assign pick_idx   = oh2idx(pick);

  arb_pick u_pick (
    .mode     (mode),
    .elig     (elig),
    .last     (last),
    .last_ext (last_ext),
    .pick     (pick)
  );

  arb_retry_mask #(.TW(TW)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (gnt & {NREQ{retry_hit}}),
    .lim    (retry_lim),
    .masked (masked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt      <= '0;
      dead     <= 1'b0;
      last     <= IW'(NREQ-1);
      last_ext <= IW'(NREQ-1);
      idle_q   <= 1'b1;
      dcnt     <= '0;
    end else begin
      idle_q <= bus_idle;
      dead   <= timeout;
      if (retry_hit || timeout)
        gnt <= '0;
      else if (rearb)
        gnt <= pick;
      if (rearb && (pick != '0)) begin
        last <= pick_idx;
        if (pick_idx != '0) last_ext <= pick_idx;
      end
      if (!bus_idle || retry_hit || timeout || rearb)
        dcnt <= '0;
      else if (have_owner && (dead_lim != '0) && !lock)
        dcnt <= dnext[TW-1:0];
    end
  end

  for (genvar i = 0; i < NREQ; i++) begin : g_dead
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dead_vec[i] <= 1'b0;
      else if (timeout && gnt[i])
        dead_vec[i] <= 1'b1;
      else if (!req[i])
        dead_vec[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/arb_checks.sv
module arb_checks
  import arb_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req,
  input logic            bus_idle,
  input logic            retry,
  input logic            lock,
  input logic [NREQ-1:0] gnt,
  input logic            dead
);
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0 && bus_idle && !lock) |=> (gnt == '0));

  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_idle && !retry && !lock) |=> $stable(gnt));

  a_r7_retry_release: assert property (@(posedge clk) disable iff (!rst_n)
    (retry && gnt != '0 && !lock) |=> (gnt == '0));

  a_r8_dead_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    dead |-> (gnt == '0));

  a_r10_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(gnt));
endmodule

bind bus_arbiter4 arb_checks u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req),
  .bus_idle (bus_idle),
  .retry    (retry),
  .lock     (lock),
  .gnt      (gnt),
  .dead     (dead)
);

// File: tb/sim_bus_arbiter4.sv
module sim_bus_arbiter4;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    req = '0;
  logic          bus_idle = 1'b1;
  logic          retry = 1'b0;
  logic          lock = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [TW-1:0] dead_lim = '0;
  logic [TW-1:0] retry_lim = '0;
  logic [3:0]    gnt;
  logic          dead;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_arbiter4 #(.TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .bus_idle(bus_idle),
    .retry(retry), .lock(lock), .mode(mode), .dead_lim(dead_lim),
    .retry_lim(retry_lim), .gnt(gnt), .dead(dead)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_g(string tag, logic [3:0] exp);
    checks++;
    if (gnt !== exp) begin
      failures++;
      $display("FAIL %s gnt actual=%b expected=%b", tag, gnt, exp);
    end
  endtask

  task automatic chk_d(string tag, logic exp);
    checks++;
    if (dead !== exp) begin
      failures++;
      $display("FAIL %s dead actual=%b expected=%b", tag, dead, exp);
    end
  endtask

  task automatic tx();
    bus_idle = 1'b0; step();
    bus_idle = 1'b1; step();
  endtask

  task automatic t_reset();
    step(); step();
    chk_g("R1 reset", 4'b0000);
    chk_d("R1 reset", 1'b0);
    rst_n = 1'b1;
    step();
    chk_g("R1 idle no request", 4'b0000);
  endtask

  task automatic t_fixed();
    mode = 2'd0;
    req = 4'b1111; step(); chk_g("R2 fixed host first", 4'b0001);
    req = 4'b1110; step(); chk_g("R2 fixed m0", 4'b0010);
    req = 4'b1100; step(); chk_g("R2 fixed m1", 4'b0100);
    req = 4'b1000; step(); chk_g("R2 fixed m2", 4'b1000);
    req = 4'b0000; step(); chk_g("R1 no request", 4'b0000);
  endtask

  task automatic t_rotate();
    mode = 2'd1;
    req = 4'b1111; step(); chk_g("R3 rotate start", 4'b0001);
    req = 4'b1110; step(); chk_g("R3 rotate next", 4'b0010);
    req = 4'b1101; step(); chk_g("R3 rotate skips host", 4'b0100);
    req = 4'b1011; step(); chk_g("R3 rotate top", 4'b1000);
    req = 4'b0111; step(); chk_g("R3 rotate wrap", 4'b0001);
    req = 4'b0000; step(); chk_g("R1 no request", 4'b0000);
  endtask

  task automatic t_hybrid();
    mode = 2'd2;
    req = 4'b1111; step(); chk_g("R4 hybrid host", 4'b0001);
    req = 4'b1110; step(); chk_g("R4 hybrid ext wrap", 4'b0010);
    req = 4'b1101; step(); chk_g("R4 hybrid host returns", 4'b0001);
    req = 4'b1100; step(); chk_g("R4 hybrid ext rotates", 4'b0100);
    req = 4'b0000; step(); chk_g("R1 no request", 4'b0000);
  endtask

  task automatic t_pingpong();
    mode = 2'd3;
    req = 4'b1111; step(); chk_g("R5 pingpong host after ext", 4'b0001);
    tx(); chk_g("R5 pingpong ext after host", 4'b1000);
    tx(); chk_g("R5 pingpong host again", 4'b0001);
    tx(); chk_g("R5 pingpong ext rotated", 4'b0010);
    req = 4'b0000; step(); chk_g("R1 no request", 4'b0000);
  endtask

  task automatic t_hold();
    mode = 2'd0;
    req = 4'b0010; step(); chk_g("R6 grant m0", 4'b0010);
    bus_idle = 1'b0; req = 4'b0001;
    step(); chk_g("R6 busy hold", 4'b0010);
    step(); chk_g("R6 busy hold 2", 4'b0010);
    bus_idle = 1'b1; step(); chk_g("R6 regrant at idle", 4'b0001);
  endtask

  task automatic t_retry();
    retry_lim = 4'd3;
    req = 4'b0011; bus_idle = 1'b0; retry = 1'b1;
    step(); chk_g("R7 retry clears", 4'b0000);
    retry = 1'b0; bus_idle = 1'b1;
    step(); chk_g("R7 masked host skipped", 4'b0010);
    req = 4'b0001;
    step(); chk_g("R7 mask cycle", 4'b0000);
    step(); chk_g("R7 mask last cycle", 4'b0000);
    step(); chk_g("R7 mask expired", 4'b0001);
    retry_lim = 4'd0;
    bus_idle = 1'b0; retry = 1'b1;
    step(); chk_g("R7 retry clears lim0", 4'b0000);
    retry = 1'b0; bus_idle = 1'b1;
    step(); chk_g("R7 no mask lim0", 4'b0001);
  endtask

  task automatic t_dead();
    req = 4'b0000; step(); chk_g("R8 cleared", 4'b0000);
    dead_lim = 4'd3; req = 4'b0011;
    step(); chk_g("R8 grant cycle0", 4'b0001);
    step(); chk_g("R8 grant cycle1", 4'b0001);
    step(); chk_g("R8 grant cycle2", 4'b0001);
    chk_d("R8 not yet dead", 1'b0);
    step(); chk_g("R8 timeout release", 4'b0000);
    chk_d("R8 dead pulse", 1'b1);
    step(); chk_g("R9 dead host skipped", 4'b0010);
    chk_d("R8 dead one cycle", 1'b0);
    dead_lim = 4'd0; req = 4'b0001;
    step(); chk_g("R9 dead host still excluded", 4'b0000);
    req = 4'b0000; step();
    req = 4'b0001; step(); chk_g("R9 host back after drop", 4'b0001);
    for (int i = 0; i < 20; i++) step();
    chk_g("R8 lim0 no timeout", 4'b0001);
    chk_d("R8 lim0 no dead", 1'b0);
  endtask

  task automatic t_lock();
    lock = 1'b1; req = 4'b0010;
    step(); chk_g("R10 lock holds owner", 4'b0001);
    step(); chk_g("R10 lock holds 2", 4'b0001);
    retry = 1'b1;
    step(); chk_g("R10 retry ignored", 4'b0001);
    retry = 1'b0; lock = 1'b0;
    step(); chk_g("R10 release after unlock", 4'b0010);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_fixed();
    t_rotate();
    t_hybrid();
    t_pingpong();
    t_hold();
    t_retry();
    t_dead();
    t_lock();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule